// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives PHY management frames from a pair of 32-bit registers on a simple register bus. The control register holds the MDC divider and the preamble switch, and it shows a busy flag. The command register takes the serial frame as one word: start code, opcode, PHY address, register address, turnaround and data. Writing that register while the block is idle starts a transaction. The block first sends an optional run of 32 ones, then shifts the word out MSB first on MDIO, with MDC produced from the system clock.

For a read, the block releases the data line for the turnaround and for the sixteen data bit times. It samples the PHY's answer on the rising edges of MDC and places it in the low half of the command register. Software polls the busy flag and then reads the result back.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the control register (offset 0x0) and the command register (offset 0x4) both read 0, MDC is low and the MDIO output enable is low.
- R2: The control register reads back as follows: bits [6:0] hold the divider, bit 7 holds the preamble enable and bit 8 is the busy flag. Writes cannot change bit 8, and bits [31:9] read 0.
- R3: A write to offset 0x4 while idle starts a frame, and busy reads 1 on the clock after that write. Busy stays high for exactly 2·H·N system clocks. H is the MDC half period and N is 64 with the preamble enabled or 32 without it.
- R4: Each MDC high phase and each low phase lasts H = div+1 system clocks, where a divider of 0 acts as 1. MDC is low whenever busy is low.
- R5: With the preamble enabled, the MDIO output carries 32 ones and then command bits 31 down to 0. With the preamble disabled it carries command bits 31 down to 0 only.
- R6: MDIO changes only when MDC falls or when a frame starts. It holds its value across each MDC rising edge and through the whole high phase.
- R7: A frame whose command bits [29:28] equal 2 (read) keeps the output enable low for the last 18 bit times: 2 turnaround bits and 16 data bits. It captures MDIO input on the 16 data rising edges, MSB first, into command bits [15:0]. Bits [31:16] keep the written values.
- R8: A frame with any other opcode (1 = write) keeps the output enable high for every bit, and the command register keeps the written word.
- R9: A write to offset 0x4 while busy is ignored: no new frame starts and the register contents do not change.
- R10: When no frame is running, the output enable is low and MDC is low. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
Corrupted state in the bit position or preamble counter shows up at the ports within one frame. The busy window grows or shrinks from its exact 2·H·N length, and the bit stream seen on MDC rising edges stops matching the command word. A wrong clock divider changes the length of the very first MDC high phase, and a wrong read window shows up as a shifted or inverted word in the command register once busy clears. An accept path that ignores busy gives a second frame or an overwritten command word, which is visible in the next register read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned RDW      = 16;
  localparam int unsigned TA_TOP   = RDW + 1;
  localparam int unsigned OP_LSB   = 28;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned CMD_OFS  = 4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_OTHER = 2'd3
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, tick;

  always_comb begin
    lim      = (div == '0) ? DIV_W'(1) : div;
    tick     = run && (cnt_q == lim);
    cnt_d    = cnt_q;
    mdc_d    = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;

  // R4: a strobe can only happen while running, and both never together
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] div_in,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             busy,
  output logic [DIV_W-1:0] div_run,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rd_valid,
  output logic [RDW-1:0]   rd_word
);
  localparam int unsigned PRE_W = $clog2(PRE_LEN + 1);
  localparam int unsigned POS_W = $clog2(CMD_W);
  localparam logic [POS_W-1:0] POS_TOP = POS_W'(CMD_W - 1);
  localparam logic [POS_W-1:0] POS_TA  = POS_W'(TA_TOP);
  localparam logic [POS_W-1:0] POS_RDW = POS_W'(RDW);

  logic             busy_q, busy_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [CMD_W-1:0] sh_q, sh_d;
  logic             rd_q, rd_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [RDW-1:0]   cap_q, cap_d;
  logic             in_frame, last_fall;

  assign in_frame  = busy_q && (pre_q == '0);
  assign last_fall = in_frame && fall_stb && (pos_q == '0);

  always_comb begin
    busy_d = busy_q;
    pre_d  = pre_q;
    pos_d  = pos_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    div_d  = div_q;
    cap_d  = cap_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = cmd;
        pre_d  = pre_en ? PRE_W'(PRE_LEN) : '0;
        pos_d  = POS_TOP;
        rd_d   = (mdio_op_e'(cmd[OP_LSB+1:OP_LSB]) == OP_READ);
        div_d  = div_in;
        cap_d  = '0;
      end
    end else begin
      if (rise_stb && in_frame && rd_q && (pos_q < POS_RDW))
        cap_d = {cap_q[RDW-2:0], mdio_i};
      if (fall_stb) begin
        if (pre_q != '0) begin
          pre_d = pre_q - 1'b1;
        end else if (pos_q == '0) begin
          busy_d = 1'b0;
        end else begin
          pos_d = pos_q - 1'b1;
          sh_d  = {sh_q[CMD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      pos_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      div_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      pos_q  <= pos_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      div_q  <= div_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign div_run  = div_q;
  assign mdio_o   = (!busy_q || (pre_q != '0)) ? 1'b1 : sh_q[CMD_W-1];
  assign mdio_oe  = busy_q && !(in_frame && rd_q && (pos_q <= POS_TA));
  assign rd_valid = last_fall && rd_q;
  assign rd_word  = cap_q;

  // R3: an accepted start raises busy on the next clock
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  // R6: the line value never moves on an MDC rising edge
  a_r6_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> $stable(mdio_o));
  // R7: the bus is released whenever a read data bit is sampled
  a_r7_released_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && in_frame && rd_q && (pos_q < POS_RDW)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic              busy,
  input  logic              rd_valid,
  input  logic [RDW-1:0]    rd_word,
  output logic [CMD_W-1:0]  rdata,
  output logic [DIV_W-1:0]  div,
  output logic              pre_en,
  output logic              start
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
  localparam int unsigned PAD_W = CMD_W - DIV_W - 2;

  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_q, pre_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             sel_ctrl, sel_cmd;

  assign sel_ctrl = (addr == A_CTRL);
  assign sel_cmd  = (addr == A_CMD);
  assign start    = wr && sel_cmd && !busy;

  always_comb begin
    div_d = div_q;
    pre_d = pre_q;
    cmd_d = cmd_q;
    if (wr && sel_ctrl) begin
      div_d = wdata[DIV_W-1:0];
      pre_d = wdata[DIV_W];
    end
    if (start)
      cmd_d = wdata;
    else if (rd_valid)
      cmd_d[RDW-1:0] = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)
      rdata = {{PAD_W{1'b0}}, busy, pre_q, div_q};
    else if (sel_cmd)
      rdata = cmd_q;
  end

  assign div    = div_q;
  assign pre_en = pre_q;

  // R9: a command write during a frame leaves the register untouched
  a_r9_ignored_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_cmd && busy && !rd_valid) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0] div_cfg, div_run;
  logic             pre_en, start, busy;
  logic             rise_stb, fall_stb, rd_valid;
  logic [RDW-1:0]   rd_word;

  mdio_csr #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word),
    .rdata(reg_rdata), .div(div_cfg), .pre_en(pre_en), .start(start)
  );

  mdio_frame_seq #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(reg_wdata),
    .pre_en(pre_en), .div_in(div_cfg), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .mdio_i(mdio_i), .busy(busy), .div_run(div_run),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_run),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // R4 / R10: clock and line driver are quiet outside a frame
  a_r4_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r10_oe_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/test_mdio_frame_master.sv
`timescale 1ns/1ps
module test_mdio_frame_master;
  logic        clk, rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int vectors = 0;
  int miscompares = 0;

  mdio_frame_master i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural PHY: records driven bits, answers read windows
  logic [95:0] mon_bits;
  int          mon_n, rd_k;
  logic [15:0] rd_pat;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      mon_bits = {mon_bits[94:0], mdio_o};
      mon_n++;
    end else begin
      rd_k++;
    end
  end

  assign mdio_i = (rd_k == 0) ? 1'b1 :
                  (rd_k == 1) ? 1'b0 :
                  (rd_k <= 17) ? rd_pat[17 - rd_k] : 1'b1;

  // port-level timing monitors for R4 and R6
  int   exp_half, hi_run, lo_run, per_bad, r6_bad;
  logic prev_o, prev_mdc;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && (mdio_o !== prev_o)) r6_bad++;
      if (mdc) hi_run++;
      else if (busy_seen()) lo_run++;
      if (prev_mdc && !mdc) begin
        if (hi_run != exp_half) per_bad++;
        hi_run = 0;
      end
      if (!prev_mdc && mdc) begin
        if (lo_run != exp_half) per_bad++;
        lo_run = 0;
      end
    end
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  function automatic logic busy_seen();
    return mdio_oe || mdc || (lo_run > 0) || mon_n > 0 || rd_k > 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input int half);
    mon_bits = '0; mon_n = 0; rd_k = 0;
    hi_run = 0; lo_run = 0; per_bad = 0; r6_bad = 0;
    exp_half = half;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'h0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_addr = 4'h0;
    #1;
    while (reg_rdata[8]) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_frame(input logic [31:0] cmd, input bit pre,
                           input logic [6:0] div, output int blen);
    int half;
    half = ((div == 0) ? 1 : int'(div)) + 1;
    bus_write(4'h0, {24'h0, pre, div});
    clear_mon(half);
    bus_write(4'h4, cmd);
    wait_idle(blen);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(4'h0, d);
    chk(d == 32'h0, "R1 ctrl after reset", d, 0);
    bus_read(4'h4, d);
    chk(d == 32'h0, "R1 cmd after reset", d, 0);
    chk(!mdc && !mdio_oe, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);
    bus_read(4'h8, d);
    chk(d == 32'h0, "R10 unmapped offset reads 0", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, d);
    chk(d == 32'h0000_00FF, "R2 ctrl readback, busy not writable", d, 32'hFF);
    bus_write(4'h0, 32'h0000_009A);
    bus_read(4'h0, d);
    chk(d == 32'h0000_009A, "R2 ctrl typical value", d, 32'h9A);
  endtask

  task automatic t_write_pre();
    logic [31:0] cmd, d;
    int blen;
    cmd = {2'b01, 2'b01, 5'h05, 5'h11, 2'b10, 16'hBEEF};
    run_frame(cmd, 1'b1, 7'h1A, blen);
    chk(blen == 64 * 2 * 27, "R3 busy length with preamble", blen, 3456);
    chk(mon_n == 64, "R8 oe high for every write bit", mon_n, 64);
    chk(mon_bits[63:0] == {32'hFFFF_FFFF, cmd}, "R5 preamble then command",
        mon_bits[63:0], {32'hFFFF_FFFF, cmd});
    chk(per_bad == 0, "R4 MDC phase length div 0x1A", per_bad, 0);
    chk(r6_bad == 0, "R6 MDIO stable while MDC high", r6_bad, 0);
    bus_read(4'h4, d);
    chk(d == cmd, "R8 cmd register kept after write", d, cmd);
    chk(!mdc && !mdio_oe, "R10 idle after frame", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_write_nopre();
    logic [31:0] cmd;
    int blen;
    cmd = {2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h0001};
    run_frame(cmd, 1'b0, 7'd3, blen);
    chk(blen == 32 * 2 * 4, "R3 busy length without preamble", blen, 256);
    chk(mon_n == 32, "R5 no preamble bit count", mon_n, 32);
    chk(mon_bits[31:0] == cmd, "R5 frame starts at start code",
        mon_bits[31:0], cmd);
    chk(per_bad == 0, "R4 MDC phase length div 3", per_bad, 0);
  endtask

  task automatic t_read(input bit pre, input logic [6:0] div,
                        input logic [15:0] pat, input int exp_len);
    logic [31:0] cmd, d;
    int blen, nb;
    cmd = {2'b01, 2'b10, 5'h0A, 5'h15, 2'b10, 16'h0000};
    rd_pat = pat;
    nb = pre ? 64 : 32;
    run_frame(cmd, pre, div, blen);
    chk(blen == exp_len, "R4 R3 busy length for read", blen, exp_len);
    chk(mon_n == nb - 18, "R7 oe low for last 18 bits", mon_n, nb - 18);
    chk(rd_k == 18, "R7 released bit count", rd_k, 18);
    chk(mon_bits[13:0] == cmd[31:18], "R7 header bits driven",
        mon_bits[13:0], cmd[31:18]);
    bus_read(4'h4, d);
    chk(d == {cmd[31:16], pat}, "R7 captured read data", d, {cmd[31:16], pat});
    chk(r6_bad == 0, "R6 MDIO stable during read frame", r6_bad, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] c1, c2, d;
    int blen;
    c1 = {2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h5A5A};
    c2 = {2'b01, 2'b10, 5'h1C, 5'h1B, 2'b10, 16'hFFFF};
    bus_write(4'h0, 32'h0000_0001);
    clear_mon(2);
    bus_write(4'h4, c1);
    repeat (20) @(negedge clk);
    bus_write(4'h4, c2);
    bus_read(4'h4, d);
    chk(d == c1, "R9 cmd unchanged by write while busy", d, c1);
    wait_idle(blen);
    bus_read(4'h4, d);
    chk(d == c1, "R9 cmd after frame", d, c1);
    chk(mon_n == 32 && mon_bits[31:0] == c1, "R9 only first frame sent",
        mon_bits[31:0], c1);
    repeat (10) @(negedge clk);
    chk(mon_n == 32 && !mdc, "R9 no second frame started", mon_n, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd_pat = '0;
    clear_mon(2);
    prev_o = 1'b1; prev_mdc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_write_pre();
    t_write_nopre();
    t_read(1'b1, 7'd2, 16'hA5C3, 64 * 2 * 3);
    t_read(1'b0, 7'd0, 16'h8001, 32 * 2 * 2);
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule